// File: doc/BRIEF.md
# Token Tunneling Round-Robin Arbiter

The block picks one winner per cycle from N request lines in round-robin order. A token is injected at the position held in the pointer register. It travels through one small cell per request line, in increasing index order, and wraps from the last line back to line 0. The first requesting cell the token reaches takes the grant and absorbs the token. The grant is combinational from the request vector and the current pointer. On the next clock edge the pointer moves to one past the winner.

Cells are collected into groups of `GRP_SIZE`. Every group has a bypass path. When all of a group's requests are low, the bypass carries the token straight from the group's entry to its exit. Because of this, the worst-case path length grows with the number of groups and not with the number of ports. When `HIER` is set, each group is built as a binary tree of bypassed blocks. The leaves are subgroups of `SUB_SIZE` cells, and the tree is log2(`GRP_SIZE`/`SUB_SIZE`) levels deep, so the token also skips idle stretches inside the group where it starts and the group where it stops. To break the combinational cycle, the ring is laid out twice in a row. The first copy receives the injected token, and the second copy only continues a token that passed through the first copy without being absorbed.

Typical use is output-contention resolution in a switch fabric. `req_i` carries one bit per contending input, and `gnt_o` is the selected input in one-hot form.

Top module: `tunnel_rr_arb`

## Requirements
- R1: `gnt_o` has at most one bit set, and a set bit is always one whose `req_i` bit is also set.
- R2: Whenever at least one `req_i` bit is high, exactly one `gnt_o` bit is high in the same cycle.
- R3: The granted index is the first set request found by scanning upward from the pointer value (the pointer position included) and wrapping from N-1 to 0.
- R4: After a cycle with a grant at index k, `ptr_o` holds (k+1) mod N, so a grant at N-1 wraps the pointer to 0.
- R5: In a cycle with no request, `gnt_o` is all zero and `ptr_o` keeps its value across the following edge.
- R6: While `rst_n` is low, the pointer is cleared to 0. Straight after reset, the lowest-numbered request therefore wins.
- R7: With `HIER` set to 1 and with `HIER` set to 0, the grant is identical for every request vector and pointer value.
- R8: A lone request at index (pointer-1) mod N, the position farthest from the pointer, is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pointer register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer |
| req_i | input | N_PORTS | One request bit per contending input |
| gnt_o | output | N_PORTS | One-hot grant, all zero when there is no request |
| ptr_o | output | $clog2(N_PORTS) | Current round-robin pointer, the first position the token visits |

## Verification
A corrupted pointer shows up at `gnt_o` in the first cycle whose request vector has set bits on both sides of the pointer's true position. It also shows up directly on `ptr_o` one edge after the grant that should have set it. A broken bypass or a broken ripple link appears in the same cycle: depending on where the token is lost or leaks, either no grant is issued although a request is pending, or the grant goes to a request past the first one. The bench runs the tree-bypass and flat-bypass variants side by side on the same inputs, so a fault in only one topology appears as a mismatch between the two in that same cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;

    // Increment modulo a port count: returns 0 when the incremented value reaches cnt.
    function automatic int unsigned wrap_inc(int unsigned val, int unsigned cnt);
        return (val + 1 == cnt) ? 0 : val + 1;
    endfunction

endpackage

// File: rtl/tt_leaf.sv
// Linear ripple of token cells with a bypass across the whole span.
module tt_leaf #(
    parameter int W = 2
) (
    input  logic         tok_i,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] inj_i,
    output logic [W-1:0] gnt_o,
    output logic         tok_o,
    output logic         idle_o,
    output logic         inj_any_o
);
    logic [W:0] chain;
    logic [W-1:0] live;

    assign chain[0] = tok_i;

    for (genvar c = 0; c < W; c++) begin : g_cell
        assign live[c]      = chain[c] | inj_i[c];
        assign gnt_o[c]     = live[c] & req_i[c];
        assign chain[c + 1] = live[c] & ~req_i[c];
    end

    assign idle_o    = ~|req_i;
    assign inj_any_o = |inj_i;
    // Bypass: an idle span passes an arriving or locally injected token straight out.
    assign tok_o     = idle_o ? (tok_i | inj_any_o) : chain[W];
endmodule

// File: rtl/tt_group.sv
// One group of GW cells. HIER=1 nests bypasses as a binary tree over SUBW-cell leaves;
// HIER=0 uses a single leaf covering the whole group.
module tt_group #(
    parameter int GW   = 8,
    parameter int SUBW = 2,
    parameter int HIER = 1
) (
    input  logic          tok_i,
    input  logic [GW-1:0] req_i,
    input  logic [GW-1:0] inj_i,
    output logic [GW-1:0] gnt_o,
    output logic          tok_o
);
    localparam int LW = (HIER != 0) ? SUBW : GW;
    localparam int NL = GW / LW;
    localparam int NN = 2 * NL;

    // Heap-ordered tree nodes: node 1 is the root, nodes NL..NN-1 are the leaves.
    logic [NN-1:1] nd_in;
    logic [NN-1:1] nd_out;
    logic [NN-1:1] nd_idle;
    logic [NN-1:1] nd_inj;

    assign nd_in[1] = tok_i;
    assign tok_o    = nd_out[1];

    for (genvar k = 1; k < NN; k++) begin : g_node
        if (k >= NL) begin : g_leaf
            tt_leaf #(.W(LW)) i_leaf (
                .tok_i     (nd_in[k]),
                .req_i     (req_i[(k - NL) * LW +: LW]),
                .inj_i     (inj_i[(k - NL) * LW +: LW]),
                .gnt_o     (gnt_o[(k - NL) * LW +: LW]),
                .tok_o     (nd_out[k]),
                .idle_o    (nd_idle[k]),
                .inj_any_o (nd_inj[k])
            );
        end else begin : g_inner
            assign nd_in[2 * k]     = nd_in[k];
            assign nd_in[2 * k + 1] = nd_out[2 * k];
            assign nd_idle[k]       = nd_idle[2 * k] & nd_idle[2 * k + 1];
            assign nd_inj[k]        = nd_inj[2 * k] | nd_inj[2 * k + 1];
            assign nd_out[k]        = nd_idle[k] ? (nd_in[k] | nd_inj[k])
                                                 : nd_out[2 * k + 1];
        end
    end
endmodule

// File: rtl/tunnel_rr_arb.sv
module tunnel_rr_arb #(
    parameter int N_PORTS  = 32,
    parameter int GRP_SIZE = 8,
    parameter int SUB_SIZE = 2,
    parameter int HIER     = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORTS-1:0]         req_i,
    output logic [N_PORTS-1:0]         gnt_o,
    output logic [$clog2(N_PORTS)-1:0] ptr_o
);
    localparam int PW = $clog2(N_PORTS);
    localparam int NG = N_PORTS / GRP_SIZE;

    logic [PW-1:0]            ptr_q;
    logic [PW-1:0]            ptr_d;
    logic [PW-1:0]            gnt_idx;
    logic [N_PORTS-1:0]       inj;
    logic [1:0][N_PORTS-1:0]  pass_inj;
    logic [1:0][N_PORTS-1:0]  pass_gnt;
    logic [2*NG:0]            tok;

    assign inj         = N_PORTS'(1) << ptr_q;
    assign pass_inj[0] = inj;
    assign pass_inj[1] = '0;
    assign tok[0]      = 1'b0;

    // Ring unrolled twice: copy 0 takes the injected token, copy 1 carries the wrap.
    for (genvar p = 0; p < 2; p++) begin : g_pass
        for (genvar g = 0; g < NG; g++) begin : g_grp
            tt_group #(.GW(GRP_SIZE), .SUBW(SUB_SIZE), .HIER(HIER)) i_grp (
                .tok_i (tok[p * NG + g]),
                .req_i (req_i[g * GRP_SIZE +: GRP_SIZE]),
                .inj_i (pass_inj[p][g * GRP_SIZE +: GRP_SIZE]),
                .gnt_o (pass_gnt[p][g * GRP_SIZE +: GRP_SIZE]),
                .tok_o (tok[p * NG + g + 1])
            );
        end
    end

    assign gnt_o = pass_gnt[0] | pass_gnt[1];

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (gnt_o[i]) gnt_idx = gnt_idx | PW'(i);
        end
    end

    assign ptr_d = (|req_i) ? PW'(tt_pkg::wrap_inc(32'(gnt_idx), N_PORTS)) : ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // Grant of the previous cycle, used to check the pointer update.
    logic [N_PORTS-1:0] gnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gnt_q <= '0;
        else        gnt_q <= gnt_o;
    end

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R1
    gnt_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);
    // R2
    gnt_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> ($countones(gnt_o) == 1));
    // R4
    ptr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_q) |-> gnt_q[ptr_o - PW'(1)]);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |=> $stable(ptr_o));
    // R5
    idle_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_i) |-> (gnt_o == '0));
endmodule

// File: tb/test_tunnel_rr_arb.sv
module test_tunnel_rr_arb;
    localparam int N  = 32;
    localparam int PW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  gnt_h, gnt_f;
    logic [PW-1:0] ptr_h, ptr_f;

    int checks = 0;
    int errors = 0;
    int mptr   = 0;

    always #2 clk = ~clk;

    tunnel_rr_arb #(.N_PORTS(N), .GRP_SIZE(8), .SUB_SIZE(2), .HIER(1)) i_tunnel_rr_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt_h), .ptr_o(ptr_h));

    tunnel_rr_arb #(.N_PORTS(N), .GRP_SIZE(8), .SUB_SIZE(2), .HIER(0)) i_flat (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gnt_o(gnt_f), .ptr_o(ptr_f));

    localparam logic [N-1:0] VEC [12] = '{
        32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
        32'h0001_0100, 32'h0000_0003, 32'h4000_0002, 32'h0000_0000,
        32'h00F0_0000, 32'h8000_0001, 32'h1000_0000, 32'hAAAA_AAAA
    };

    function automatic logic [N-1:0] model_gnt(logic [N-1:0] r, int p);
        for (int i = 0; i < N; i++) begin
            if (r[(p + i) % N]) return N'(1) << ((p + i) % N);
        end
        return '0;
    endfunction

    function automatic int model_next(logic [N-1:0] r, int p);
        for (int i = 0; i < N; i++) begin
            if (r[(p + i) % N]) return (p + i + 1) % N;
        end
        return p;
    endfunction

    task automatic check(bit ok, string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One arbitration cycle: grant checked mid-cycle, pointer after the edge.
    task automatic step(logic [N-1:0] r, string tag);
        logic [N-1:0] eg;
        @(negedge clk);
        req = r;
        #1;
        eg = model_gnt(r, mptr);
        check(gnt_h === eg, {tag, " R3 grant"}, gnt_h, eg);
        check(gnt_f === gnt_h, "R7 flat vs tree", gnt_f, gnt_h);
        @(posedge clk);
        #1;
        mptr = model_next(r, mptr);
        check(ptr_h === PW'(mptr), (|r) ? "R4 pointer" : "R5 pointer hold",
              N'(ptr_h), N'(mptr));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(ptr_h === '0, "R6 reset pointer", N'(ptr_h), '0);
        rst_n = 1'b1;
        #1;
        check(gnt_h === '0, "R5 no request no grant", gnt_h, '0);

        // R6: right after reset the lowest index wins
        step(32'h0000_0C00, "R6 first after reset");

        for (int v = 0; v < 12; v++) step(VEC[v], "table");

        // R4: grant at N-1 wraps pointer to 0
        step(32'h8000_0000, "R4 wrap");
        check(ptr_h === '0, "R4 wrap to zero", N'(ptr_h), '0);

        // R5: idle cycles leave pointer unchanged
        step(32'h0000_0040, "R5 setup");
        step('0, "R5 idle");
        step('0, "R5 idle2");

        // R8: lone request farthest from pointer
        for (int k = 0; k < 6; k++) begin
            step(N'(1) << ((mptr + N - 1) % N), "R8 farthest");
            step(N'(1) << ((mptr + 5 * k + 3) % N), "R8 move pointer");
        end

        // R2/R3/R7: sparse and dense random patterns
        for (int t = 0; t < 400; t++) begin
            logic [N-1:0] r;
            r = $urandom();
            if (t % 3 == 0) r = r & $urandom() & $urandom() & $urandom();
            if (t % 7 == 0) r = '0;
            step(r, "R2 random");
            checks++;
            if ((|r) && $countones(gnt_h) != 1) begin
                errors++;
                $display("FAIL R2 grant count actual=%0d expected=%0d", $countones(gnt_h), 1);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule